// File: doc/BRIEF.md
# Tick-Driven Interval Timer with Interrupt Entry

This block counts down a 16-bit value once per incoming tick. When a decrement takes the value from zero to all ones, it tests three conditions: interrupts are enabled in the status byte, the handler vector is nonzero, and the timer's mask bit is clear. If all three hold, the block takes over from the core for a fixed window of cycles. It pushes the status byte and a three-byte return address onto the stack, one byte per cycle. It then hands the core a lowered stack pointer, a status byte with interrupt enable cleared, and a program counter loaded from the vector.

The core feeds in its live stack pointer, status byte and program counter, and holds instruction issue for as long as `busy_o` is high. It applies the three register updates in the one cycle where their write strobes are raised. Every stack byte goes to the top 64 KiB page of a 20-bit byte space. Ticks that arrive during the entry window are kept in a small saturating backlog. The backlog is drained one per cycle once the window closes, so the count does not lose time.

Top module: `tick_irq_timer`

## Requirements
- R1: When idle and not loading, each cycle with a tick or a nonzero backlog lowers `count_o` by exactly one at the next clock edge, and 0x0000 wraps to 0xFFFF.
- R2: A load strobe puts `cnt_ld_val_i` into `count_o` at the next edge and suppresses any decrement in that cycle.
- R3: A wrap starts entry only if status bit 7 (interrupt enable) is 1, `vector_i` is nonzero and bit 4 of `mask_i` is 0. Any other wrap leaves `busy_o` low and writes nothing.
- R4: Entry writes four bytes in the first four busy cycles. The order is: status byte at SP-1, then PC bits 7:0 at SP-4, PC bits 15:8 at SP-3, and PC bits 19:16 (upper nibble zero) at SP-2. Each 16-bit offset wraps modulo 2^16 and is placed under upper address nibble 0xF.
- R5: In the fifth busy cycle `sp_wr_o`, `psw_wr_o` and `pc_wr_o` rise together for one cycle. They carry SP-4, the status byte with bit 7 cleared, and the vector zero-extended to 20 bits.
- R6: `busy_o` rises at the edge that takes entry and stays high for exactly 9 cycles.
- R7: Ticks are never lost. Ticks seen while busy or while loading go to a backlog that saturates at 15, and the backlog is drained one per idle cycle.
- R8: While `busy_o` is high and no load is applied, `count_o` holds its value.
- R9: SP, status and PC are captured at the triggering edge. Later changes on `sp_i`, `psw_i` and `pc_i` do not alter the bytes or values of that entry.
- R10: During and right after reset, `count_o` is 0xFFFF, the backlog is empty, `busy_o` is low and no write strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One count tick |
| cnt_ld_i | input | 1 | Load strobe for the counter |
| cnt_ld_val_i | input | 16 | Value to load |
| mask_i | input | 16 | Interrupt mask word; bit 4 gates this timer |
| vector_i | input | 16 | Handler address; zero disables entry |
| sp_i | input | 16 | Core stack pointer |
| psw_i | input | 8 | Core status byte; bit 7 is interrupt enable |
| pc_i | input | 20 | Core return address |
| count_o | output | 16 | Current counter value |
| busy_o | output | 1 | Entry in progress; core must stall |
| mem_we_o | output | 1 | Stack byte write strobe |
| mem_addr_o | output | 20 | Stack byte address |
| mem_wdata_o | output | 8 | Stack byte data |
| sp_wr_o | output | 1 | Stack pointer update strobe |
| sp_o | output | 16 | New stack pointer |
| psw_wr_o | output | 1 | Status byte update strobe |
| psw_o | output | 8 | New status byte |
| pc_wr_o | output | 1 | Program counter update strobe |
| pc_o | output | 20 | New program counter |

## Verification
A counter result is due one edge after the tick or load that causes it. On an entry, `busy_o` rises at that same edge. The four stack writes occupy busy cycles one to four, the register updates busy cycle five, and the backlog starts draining on the first edge after busy falls. The bench drives inputs on the falling edge. At each rising edge it advances a behavioural model that turns each entry into a queue of nine per-cycle expectations. At every falling edge it compares all outputs against the head of that queue. Directed checks then sample the counter, busy flag and update values at hand-counted falling edges.

// File: rtl/tick_irq_pkg.sv
package tick_irq_pkg;

  localparam int unsigned SP_W   = 16;
  localparam int unsigned PSW_W  = 8;
  localparam int unsigned PC_W   = 20;
  localparam int unsigned VEC_W  = 16;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 20;

  // Upper address bits that place every stack access in the top page.
  localparam logic [ADDR_W-SP_W-1:0] STACK_PAGE = '1;

  // Core state frozen at the edge that starts an entry.
  typedef struct packed {
    logic [SP_W-1:0]  sp;
    logic [PSW_W-1:0] psw;
    logic [PC_W-1:0]  pc;
    logic [VEC_W-1:0] vec;
  } entry_ctx_t;

endpackage

// File: rtl/tick_irq_counter.sv
module tick_irq_counter #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PEND_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             hold_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             uflow_o
);

  localparam logic [PEND_W:0] PEND_MAX = {1'b0, {PEND_W{1'b1}}};

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [PEND_W-1:0] pend_q, pend_d;
  logic [PEND_W:0]   pend_sum;
  logic              consume, cnt_en, pend_en;

  // next state
  always_comb begin
    consume  = ~hold_i & ~ld_i & (tick_i | (pend_q != '0));
    pend_sum = {1'b0, pend_q} + {{PEND_W{1'b0}}, tick_i}
             - {{PEND_W{1'b0}}, consume};
    pend_d   = (pend_sum > PEND_MAX) ? PEND_MAX[PEND_W-1:0] : pend_sum[PEND_W-1:0];
    pend_en  = tick_i | consume;
    cnt_d    = ld_i ? ld_val_i : (cnt_q - {{(CNT_W-1){1'b0}}, 1'b1});
    cnt_en   = ld_i | consume;
    uflow_o  = consume & (cnt_q == '0);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '1;
      pend_q <= '0;
    end else begin
      if (cnt_en)  cnt_q  <= cnt_d;
      if (pend_en) pend_q <= pend_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/tick_irq_gate.sv
module tick_irq_gate #(
  parameter int unsigned VEC_W = 16
) (
  input  logic             ie_i,
  input  logic             mask_bit_i,
  input  logic [VEC_W-1:0] vec_i,
  output logic             take_o
);

  always_comb begin
    take_o = ie_i & ~mask_bit_i & (vec_i != '0);
  end

endmodule

// File: rtl/tick_irq_seq.sv
module tick_irq_seq
  import tick_irq_pkg::*;
#(
  parameter int unsigned ENTRY_CYC = 9,
  parameter int unsigned IE_BIT    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  entry_ctx_t        ctx_i,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  output logic              sp_wr_o,
  output logic [SP_W-1:0]   sp_o,
  output logic              psw_wr_o,
  output logic [PSW_W-1:0]  psw_o,
  output logic              pc_wr_o,
  output logic [PC_W-1:0]   pc_o
);

  // Frame layout: PC bytes low first from SP-FRAME, status byte on top.
  localparam int unsigned PC_BYTES    = (PC_W + BYTE_W - 1) / BYTE_W;
  localparam int unsigned PCX_W       = PC_BYTES * BYTE_W;
  localparam int unsigned FRAME       = PC_BYTES + 1;
  localparam int unsigned COMMIT_STEP = FRAME;
  localparam int unsigned STEP_W      = (ENTRY_CYC > 1) ? $clog2(ENTRY_CYC) : 1;
  localparam logic [STEP_W-1:0] LAST  = STEP_W'(ENTRY_CYC - 1);

  logic              busy_q, busy_d;
  logic [STEP_W-1:0] step_q, step_d;
  entry_ctx_t        ctx_q;
  logic              accept, step_en;
  logic [PCX_W-1:0]  pc_ext;
  logic              commit;

  // next state
  always_comb begin
    accept  = start_i & ~busy_q;
    busy_d  = busy_q;
    step_d  = step_q;
    if (accept) begin
      busy_d = 1'b1;
      step_d = '0;
    end else if (busy_q) begin
      if (step_q == LAST) begin
        busy_d = 1'b0;
        step_d = '0;
      end else begin
        step_d = step_q + {{(STEP_W-1){1'b0}}, 1'b1};
      end
    end
    step_en = accept | busy_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      step_q <= '0;
      ctx_q  <= '0;
    end else begin
      if (step_en) begin
        busy_q <= busy_d;
        step_q <= step_d;
      end
      if (accept) ctx_q <= ctx_i;
    end
  end

  // outputs decoded from the step register only
  always_comb begin
    pc_ext      = PCX_W'(ctx_q.pc);
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    commit      = 1'b0;
    if (busy_q) begin
      if (step_q == '0) begin
        mem_we_o    = 1'b1;
        mem_addr_o  = {STACK_PAGE, ctx_q.sp - SP_W'(1)};
        mem_wdata_o = BYTE_W'(ctx_q.psw);
      end
      for (int k = 0; k < PC_BYTES; k++) begin
        if (step_q == STEP_W'(k + 1)) begin
          mem_we_o    = 1'b1;
          mem_addr_o  = {STACK_PAGE, ctx_q.sp - SP_W'(FRAME - k)};
          mem_wdata_o = pc_ext[k*BYTE_W +: BYTE_W];
        end
      end
      if (step_q == STEP_W'(COMMIT_STEP)) commit = 1'b1;
    end
  end

  always_comb begin
    busy_o   = busy_q;
    sp_wr_o  = commit;
    psw_wr_o = commit;
    pc_wr_o  = commit;
    sp_o     = ctx_q.sp - SP_W'(FRAME);
    psw_o    = ctx_q.psw;
    psw_o[IE_BIT] = 1'b0;
    pc_o     = PC_W'(ctx_q.vec);
  end

endmodule

// File: rtl/tick_irq_timer.sv
module tick_irq_timer
  import tick_irq_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned PEND_W    = 4,
  parameter int unsigned MASK_W    = 16,
  parameter int unsigned ENTRY_CYC = 9,
  parameter int unsigned IE_BIT    = 7,
  parameter int unsigned MASK_BIT  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              cnt_ld_i,
  input  logic [CNT_W-1:0]  cnt_ld_val_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic [VEC_W-1:0]  vector_i,
  input  logic [SP_W-1:0]   sp_i,
  input  logic [PSW_W-1:0]  psw_i,
  input  logic [PC_W-1:0]   pc_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  output logic              sp_wr_o,
  output logic [SP_W-1:0]   sp_o,
  output logic              psw_wr_o,
  output logic [PSW_W-1:0]  psw_o,
  output logic              pc_wr_o,
  output logic [PC_W-1:0]   pc_o
);

  // rst_n is expected to leave reset in step with clk (synchronised upstream).

  logic       uflow, take, start;
  entry_ctx_t ctx;

  tick_irq_counter #(.CNT_W(CNT_W), .PEND_W(PEND_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_i),
    .hold_i   (busy_o),
    .ld_i     (cnt_ld_i),
    .ld_val_i (cnt_ld_val_i),
    .cnt_o    (count_o),
    .uflow_o  (uflow)
  );

  tick_irq_gate #(.VEC_W(VEC_W)) u_gate (
    .ie_i       (psw_i[IE_BIT]),
    .mask_bit_i (mask_i[MASK_BIT]),
    .vec_i      (vector_i),
    .take_o     (take)
  );

  always_comb begin
    start   = uflow & take;
    ctx.sp  = sp_i;
    ctx.psw = psw_i;
    ctx.pc  = pc_i;
    ctx.vec = vector_i;
  end

  tick_irq_seq #(.ENTRY_CYC(ENTRY_CYC), .IE_BIT(IE_BIT)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .ctx_i       (ctx),
    .busy_o      (busy_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .sp_wr_o     (sp_wr_o),
    .sp_o        (sp_o),
    .psw_wr_o    (psw_wr_o),
    .psw_o       (psw_o),
    .pc_wr_o     (pc_wr_o),
    .pc_o        (pc_o)
  );

endmodule

// File: rtl/tick_irq_checker.sv
module tick_irq_checker #(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned ENTRY_CYC = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic             cnt_ld_i,
  input logic             ie_i,
  input logic             mask_bit_i,
  input logic             vec_nz_i,
  input logic [CNT_W-1:0] count_o,
  input logic             busy_o,
  input logic             mem_we_o,
  input logic [3:0]       page_i,
  input logic             sp_wr_o,
  input logic             psw_wr_o,
  input logic             pc_wr_o,
  input logic             ie_out_i
);

  logic [7:0] run_q;

  // length of the current busy run, for the window check
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (busy_o) run_q <= run_q + 8'd1;
    else             run_q <= '0;
  end

  assert_busy_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (run_q == 8'(ENTRY_CYC)));

  assert_write_in_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> (busy_o && page_i == 4'hF));

  assert_commit_together_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pc_wr_o |-> (sp_wr_o && psw_wr_o && !ie_out_i && !mem_we_o));

  assert_frozen_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !cnt_ld_i) |=> $stable(count_o));

  assert_step_down_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !cnt_ld_i && tick_i && count_o != '0) |=> (count_o == $past(count_o) - 1'b1));

  assert_wrap_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !cnt_ld_i && tick_i && count_o == '0 && !(ie_i && vec_nz_i && !mask_bit_i))
      |=> (!busy_o && count_o == '1));

  assert_wrap_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !cnt_ld_i && tick_i && count_o == '0 && ie_i && vec_nz_i && !mask_bit_i)
      |=> busy_o);

endmodule

bind tick_irq_timer tick_irq_checker #(.CNT_W(CNT_W), .ENTRY_CYC(ENTRY_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_i     (tick_i),
  .cnt_ld_i   (cnt_ld_i),
  .ie_i       (psw_i[IE_BIT]),
  .mask_bit_i (mask_i[MASK_BIT]),
  .vec_nz_i   (|vector_i),
  .count_o    (count_o),
  .busy_o     (busy_o),
  .mem_we_o   (mem_we_o),
  .page_i     (mem_addr_o[19:16]),
  .sp_wr_o    (sp_wr_o),
  .psw_wr_o   (psw_wr_o),
  .pc_wr_o    (pc_wr_o),
  .ie_out_i   (psw_o[IE_BIT])
);

// File: tb/tick_irq_timer_tb.sv
`timescale 1ns/1ps
module tick_irq_timer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        ld = 1'b0;
  logic [15:0] ld_val = '0;
  logic [15:0] mask = '0;
  logic [15:0] vec = '0;
  logic [15:0] sp = '0;
  logic [7:0]  psw = '0;
  logic [19:0] pc = '0;

  logic [15:0] count_o;
  logic        busy_o, mem_we_o, sp_wr_o, psw_wr_o, pc_wr_o;
  logic [19:0] mem_addr_o, pc_o;
  logic [7:0]  mem_wdata_o, psw_o;
  logic [15:0] sp_o;

  always #2 clk = ~clk;

  tick_irq_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .cnt_ld_i(ld), .cnt_ld_val_i(ld_val),
    .mask_i(mask), .vector_i(vec), .sp_i(sp), .psw_i(psw), .pc_i(pc),
    .count_o(count_o), .busy_o(busy_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .sp_wr_o(sp_wr_o), .sp_o(sp_o), .psw_wr_o(psw_wr_o),
    .psw_o(psw_o), .pc_wr_o(pc_wr_o), .pc_o(pc_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  // ---------------- behavioural reference model ----------------
  typedef struct {
    bit we; int addr; int data;
    bit commit; int sp; int psw; int pc;
  } rec_t;

  rec_t q[$];
  int   m_cnt;
  int   m_pend;

  function automatic void push_entry(input int s, input int p, input int c, input int v);
    rec_t r;
    for (int i = 0; i < 9; i++) begin
      r = '{0, 0, 0, 0, 0, 0, 0};
      case (i)
        0: begin r.we = 1; r.addr = 32'hF0000 | ((s - 1) & 16'hFFFF); r.data = p; end
        1: begin r.we = 1; r.addr = 32'hF0000 | ((s - 4) & 16'hFFFF); r.data = c & 8'hFF; end
        2: begin r.we = 1; r.addr = 32'hF0000 | ((s - 3) & 16'hFFFF); r.data = (c >> 8) & 8'hFF; end
        3: begin r.we = 1; r.addr = 32'hF0000 | ((s - 2) & 16'hFFFF); r.data = (c >> 16) & 8'hF; end
        4: begin r.commit = 1; r.sp = (s - 4) & 16'hFFFF; r.psw = p & 8'h7F; r.pc = v; end
        default: ;
      endcase
      q.push_back(r);
    end
  endfunction

  always @(posedge clk or negedge rst_n) begin
    int busy_now, consume, sum;
    if (!rst_n) begin
      m_cnt  = 16'hFFFF;
      m_pend = 0;
      q.delete();
    end else begin
      busy_now = (q.size() != 0);
      if (busy_now != 0) void'(q.pop_front());
      consume = (busy_now == 0 && !ld && (tick || m_pend != 0)) ? 1 : 0;
      sum = m_pend + int'(tick) - consume;
      if (sum > 15) sum = 15;
      if (ld) m_cnt = int'(ld_val);
      else if (consume != 0) begin
        if (m_cnt == 0) begin
          m_cnt = 16'hFFFF;
          if (psw[7] && vec != 0 && !mask[4])
            push_entry(int'(sp), int'(psw), int'(pc), int'(vec));
        end else m_cnt = m_cnt - 1;
      end
      m_pend = sum;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    rec_t e;
    if (rst_n && !done) begin
      e = (q.size() != 0) ? q[0] : '{0, 0, 0, 0, 0, 0, 0};
      chk(count_o == 16'(m_cnt), "R1 R7 R8", "count", count_o, m_cnt);
      chk(busy_o == (q.size() != 0), "R6", "busy", busy_o, q.size() != 0);
      chk(mem_we_o == e.we, "R4", "we", mem_we_o, e.we);
      if (e.we) begin
        chk(int'(mem_addr_o) == e.addr, "R4 R9", "addr", mem_addr_o, e.addr);
        chk(int'(mem_wdata_o) == e.data, "R4 R9", "data", mem_wdata_o, e.data);
      end
      chk(sp_wr_o == e.commit && psw_wr_o == e.commit && pc_wr_o == e.commit,
          "R5", "strobes", {sp_wr_o, psw_wr_o, pc_wr_o}, {3{e.commit}});
      if (e.commit) begin
        chk(int'(sp_o) == e.sp, "R5 R9", "sp", sp_o, e.sp);
        chk(int'(psw_o) == e.psw, "R5 R9", "psw", psw_o, e.psw);
        chk(int'(pc_o) == e.pc, "R5 R9", "pc", pc_o, e.pc);
      end
    end
  end

  // watchdog
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 5000 && !done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=%0d expected=<5000", wd);
      wrap_up();
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- directed stimulus ----------------
  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    chk(count_o == 16'hFFFF, "R10", "reset count", count_o, 16'hFFFF);
    chk(!busy_o && !mem_we_o && !pc_wr_o, "R10", "reset strobes",
        {busy_o, mem_we_o, pc_wr_o}, 0);

    // load then three ticks
    ld = 1; ld_val = 16'd5; cyc(1);
    ld = 0; tick = 1; cyc(3);
    tick = 0;
    chk(count_o == 16'd2, "R1", "5 minus 3", count_o, 2);

    // load wins over a tick, tick lands in the backlog
    ld = 1; ld_val = 16'h1234; tick = 1; cyc(1);
    ld = 0; tick = 0;
    chk(count_o == 16'h1234, "R2", "load priority", count_o, 16'h1234);
    cyc(2);
    chk(count_o == 16'h1233, "R7", "backlog drain after load", count_o, 16'h1233);

    // blocked wraps: enable off, mask bit set, vector zero
    vec = 16'h1234; sp = 16'hFE20; pc = 20'h5ABCD;
    psw = 8'h00; mask = 16'h0000;
    ld = 1; ld_val = 16'd1; cyc(1); ld = 0; tick = 1; cyc(2); tick = 0;
    chk(count_o == 16'hFFFF && !busy_o, "R3", "ie clear", {busy_o, count_o}, 16'hFFFF);
    psw = 8'h80; mask = 16'h0010;
    ld = 1; ld_val = 16'd1; cyc(1); ld = 0; tick = 1; cyc(2); tick = 0;
    chk(count_o == 16'hFFFF && !busy_o, "R3", "masked", {busy_o, count_o}, 16'hFFFF);
    mask = 16'h0000; vec = 16'h0000;
    ld = 1; ld_val = 16'd1; cyc(1); ld = 0; tick = 1; cyc(2); tick = 0;
    chk(count_o == 16'hFFFF && !busy_o, "R3", "zero vector", {busy_o, count_o}, 16'hFFFF);

    // taken entry, inputs disturbed during the window, ticks held high
    psw = 8'h86; mask = 16'hFFEF; vec = 16'h2468; sp = 16'hFE20; pc = 20'h5ABCD;
    ld = 1; ld_val = 16'd0; cyc(1);
    ld = 0; tick = 1; cyc(1);
    chk(busy_o == 1'b1, "R3 R6", "entry taken", busy_o, 1);
    sp = 16'h1111; psw = 8'h00; pc = 20'h0; vec = 16'h0;
    cyc(4);
    chk(sp_wr_o && sp_o == 16'hFE1C, "R5 R9", "new sp", sp_o, 16'hFE1C);
    chk(psw_wr_o && psw_o == 8'h06, "R5 R9", "new psw", psw_o, 8'h06);
    chk(pc_wr_o && pc_o == 20'h02468, "R5 R9", "new pc", pc_o, 20'h02468);
    cyc(5);
    tick = 0;
    chk(!busy_o, "R6", "window closed", busy_o, 0);
    chk(count_o == 16'hFFFF, "R8", "held while busy", count_o, 16'hFFFF);
    cyc(9);
    chk(count_o == 16'hFFF6, "R7", "nine queued ticks", count_o, 16'hFFF6);

    // stack pointer wrap at the bottom of the page
    psw = 8'h80; mask = 16'h0000; vec = 16'h0100; sp = 16'h0002; pc = 20'hF0123;
    ld = 1; ld_val = 16'd0; cyc(1);
    ld = 0; tick = 1; cyc(1); tick = 0;
    chk(busy_o && mem_we_o && mem_addr_o == 20'hF0001, "R4", "status byte addr",
        mem_addr_o, 20'hF0001);
    cyc(1);
    chk(mem_addr_o == 20'hFFFFE && mem_wdata_o == 8'h23, "R4", "pc low addr",
        mem_addr_o, 20'hFFFFE);
    cyc(12);

    // backlog saturation while loading
    ld = 1; ld_val = 16'd100; tick = 1; cyc(20);
    ld = 0; tick = 0; cyc(15);
    chk(count_o == 16'd85, "R7", "backlog saturates at 15", count_o, 85);

    // wrap reached by ticking down from two
    vec = 16'h0040; sp = 16'h8000; pc = 20'h00010;
    ld = 1; ld_val = 16'd2; cyc(1);
    ld = 0; tick = 1; cyc(3); tick = 0;
    chk(busy_o == 1'b1, "R3", "entry after countdown", busy_o, 1);
    cyc(12);

    wrap_up();
  end

endmodule